// File: doc/BRIEF.md
# Integer ALU Instruction Execute Unit

This block is the execute stage for the integer subset of a 32-bit load/store RISC core. Each issued cycle it takes one 32-bit instruction word and the two source operand values already read from the register file. It decodes the register-register format and the immediate format, and computes the result. It also reports which register the result belongs to, whether it may be written, and whether the instruction is illegal or has raised an overflow trap.

All outputs are registered, so the result of an instruction issued in cycle N appears in cycle N+1. Operand extension depends on the opcode. Arithmetic immediates and set-less-than immediates are sign-extended. Logical immediates are zero-extended. The unsigned immediate compare sign-extends its immediate first and then compares without sign.

The trapping adds and subtracts raise a flag on signed overflow and suppress the write. Their non-trapping twins wrap silently. Any result aimed at register 0 is never written.

Top module: `int_exec_unit`

## Requirements
- R1: Field positions are fixed: opcode [31:26], first source [25:21], second source [20:16], destination [15:11], shift count [10:6], function [5:0], immediate [15:0]. Opcode 0 selects the register format and reports bits [15:11] as `dest_reg`. Any other opcode reports bits [20:16]. Every output reflects the instruction issued one clock earlier.
- R2: Trapping arithmetic (function 0x20 add, function 0x22 subtract, opcode 8 add sign-extended immediate) raises `ovf_trap` on signed overflow and then holds `wr_en` low. `result` still shows the wrapped value.
- R3: Non-trapping arithmetic (function 0x21, function 0x23, opcode 9 with sign-extended immediate) gives the wrapped two's-complement sum or difference and never raises `ovf_trap`.
- R4: Register logic: function 0x24 AND, 0x25 OR, 0x26 XOR, 0x27 NOR (the inverse of the OR).
- R5: Logical immediates (opcode 12 AND, 13 OR, 14 XOR) zero-extend the 16-bit immediate, so OR with 0xffff on zero gives 0x0000ffff.
- R6: Set-less-than writes 1 or 0. Function 0x2A compares signed and 0x2B compares unsigned. Opcode 10 compares signed against the sign-extended immediate. Opcode 11 compares unsigned against the sign-extended immediate.
- R7: Fixed shifts move the second source operand by the shift-count field: function 0x00 left, 0x02 right with zero fill, 0x03 right with bit-31 fill.
- R8: Variable shifts move the first source operand by the low five bits of the second operand, ignoring its upper bits: function 0x04 left, 0x06 logical right, 0x07 arithmetic right.
- R9: Opcode 15 places the immediate in bits [31:16] and zeroes bits [15:0].
- R10: A destination of register 0 never asserts `wr_en`, so the all-zero word has no effect.
- R11: Any other opcode or register-format function raises `bad_instr`, holds `wr_en` and `ovf_trap` low, and drives `result` to zero.
- R12: After reset, and in any cycle that follows a cycle with `issue_valid` low, `res_valid`, `wr_en`, `ovf_trap` and `bad_instr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Value of the register named in bits [25:21] |
| src_b | input | 32 | Value of the register named in bits [20:16] |
| res_valid | output | 1 | Outputs carry the previous cycle's instruction |
| result | output | 32 | Computed value |
| dest_reg | output | 5 | Register number the result targets |
| wr_en | output | 1 | Result may be written to `dest_reg` |
| ovf_trap | output | 1 | Trapping arithmetic overflowed |
| bad_instr | output | 1 | Opcode or function not recognised |

## Verification
The assertions check the same rules on every cycle. A trap or an illegal word never comes with a write, and register 0 is never written. Idle cycles leave every flag low. The destination field follows the format of the issued word, and load-upper always clears the low half. The values themselves can only be shown by the bench's sweep: the extension rule each opcode applies, the overflow boundaries, shift fills and masking, and the signed against unsigned ordering. That sweep runs through every opcode and every register-format function code against a table of edge operands.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SHL, ALU_SHR, ALU_SAR, ALU_LUI
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG, OPB_SEXT, OPB_ZEXT
  } opb_sel_e;

  typedef struct packed {
    alu_op_e    op;
    opb_sel_e   opb_sel;
    logic       shift_var;
    logic       trap_en;
    logic [15:0] imm;
    logic [4:0] sa;
    logic [4:0] dest;
    logic       legal;
  } dec_t;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_ADDI  = 6'd8;
  localparam logic [5:0] OPC_ADDIU = 6'd9;
  localparam logic [5:0] OPC_SLTI  = 6'd10;
  localparam logic [5:0] OPC_SLTIU = 6'd11;
  localparam logic [5:0] OPC_ANDI  = 6'd12;
  localparam logic [5:0] OPC_ORI   = 6'd13;
  localparam logic [5:0] OPC_XORI  = 6'd14;
  localparam logic [5:0] OPC_LUI   = 6'd15;

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
  import int_exec_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    dec           = '0;
    dec.op        = ALU_ADD;
    dec.opb_sel   = OPB_REG;
    dec.imm       = instr[15:0];
    dec.sa        = instr[10:6];
    dec.legal     = 1'b1;
    dec.dest      = (opc == OPC_REG) ? instr[15:11] : instr[20:16];
    if (opc == OPC_REG) begin
      case (fn)
        6'h20: begin dec.op = ALU_ADD; dec.trap_en = 1'b1; end
        6'h21: dec.op = ALU_ADD;
        6'h22: begin dec.op = ALU_SUB; dec.trap_en = 1'b1; end
        6'h23: dec.op = ALU_SUB;
        6'h24: dec.op = ALU_AND;
        6'h25: dec.op = ALU_OR;
        6'h26: dec.op = ALU_XOR;
        6'h27: dec.op = ALU_NOR;
        6'h2A: dec.op = ALU_SLT;
        6'h2B: dec.op = ALU_SLTU;
        6'h00: dec.op = ALU_SHL;
        6'h02: dec.op = ALU_SHR;
        6'h03: dec.op = ALU_SAR;
        6'h04: begin dec.op = ALU_SHL; dec.shift_var = 1'b1; end
        6'h06: begin dec.op = ALU_SHR; dec.shift_var = 1'b1; end
        6'h07: begin dec.op = ALU_SAR; dec.shift_var = 1'b1; end
        default: dec.legal = 1'b0;
      endcase
    end else begin
      case (opc)
        OPC_ADDI:  begin dec.op = ALU_ADD;  dec.opb_sel = OPB_SEXT; dec.trap_en = 1'b1; end
        OPC_ADDIU: begin dec.op = ALU_ADD;  dec.opb_sel = OPB_SEXT; end
        OPC_SLTI:  begin dec.op = ALU_SLT;  dec.opb_sel = OPB_SEXT; end
        OPC_SLTIU: begin dec.op = ALU_SLTU; dec.opb_sel = OPB_SEXT; end
        OPC_ANDI:  begin dec.op = ALU_AND;  dec.opb_sel = OPB_ZEXT; end
        OPC_ORI:   begin dec.op = ALU_OR;   dec.opb_sel = OPB_ZEXT; end
        OPC_XORI:  begin dec.op = ALU_XOR;  dec.opb_sel = OPB_ZEXT; end
        OPC_LUI:   begin dec.op = ALU_LUI;  dec.opb_sel = OPB_ZEXT; end
        default:   dec.legal = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  opb_sel_e          opb_sel,
  input  logic              shift_var,
  input  logic              trap_en,
  input  logic [15:0]       imm,
  input  logic [4:0]        sa,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              ovf
);

  localparam int SHW = $clog2(DATA_W);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] add_b;
  logic [DATA_W-1:0] sum;
  logic              is_sub;
  logic [DATA_W-1:0] sh_val;
  logic [SHW-1:0]    sh_amt;
  logic              lt_s;
  logic              lt_u;

  always_comb begin
    case (opb_sel)
      OPB_SEXT: opb = {{(DATA_W-16){imm[15]}}, imm};
      OPB_ZEXT: opb = {{(DATA_W-16){1'b0}}, imm};
      default:  opb = b;
    endcase
  end

  // one adder serves add and subtract; overflow from operand/result signs
  assign is_sub = (op == ALU_SUB);
  assign add_b  = is_sub ? ~opb : opb;
  assign sum    = a + add_b + {{(DATA_W-1){1'b0}}, is_sub};
  assign ovf    = trap_en & (a[MSB] == add_b[MSB]) & (sum[MSB] != a[MSB]);

  assign lt_s = $signed(a) < $signed(opb);
  assign lt_u = a < opb;

  assign sh_val = shift_var ? a : b;
  assign sh_amt = shift_var ? b[SHW-1:0] : SHW'(sa);

  always_comb begin
    case (op)
      ALU_ADD,
      ALU_SUB:  y = sum;
      ALU_AND:  y = a & opb;
      ALU_OR:   y = a | opb;
      ALU_XOR:  y = a ^ opb;
      ALU_NOR:  y = ~(a | opb);
      ALU_SLT:  y = {{(DATA_W-1){1'b0}}, lt_s};
      ALU_SLTU: y = {{(DATA_W-1){1'b0}}, lt_u};
      ALU_SHL:  y = sh_val << sh_amt;
      ALU_SHR:  y = sh_val >> sh_amt;
      ALU_SAR:  y = $unsigned($signed(sh_val) >>> sh_amt);
      ALU_LUI:  y = {imm, {(DATA_W-16){1'b0}}};
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              res_valid,
  output logic [DATA_W-1:0] result,
  output logic [4:0]        dest_reg,
  output logic              wr_en,
  output logic              ovf_trap,
  output logic              bad_instr
);

  dec_t              dec;
  logic [DATA_W-1:0] alu_y;
  logic              alu_ovf;
  logic              we_c;

  int_exec_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  int_exec_alu #(.DATA_W(DATA_W)) u_alu (
    .op        (dec.op),
    .opb_sel   (dec.opb_sel),
    .shift_var (dec.shift_var),
    .trap_en   (dec.trap_en),
    .imm       (dec.imm),
    .sa        (dec.sa),
    .a         (src_a),
    .b         (src_b),
    .y         (alu_y),
    .ovf       (alu_ovf)
  );

  assign we_c = dec.legal & ~alu_ovf & (dec.dest != 5'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      result    <= '0;
      dest_reg  <= '0;
      wr_en     <= 1'b0;
      ovf_trap  <= 1'b0;
      bad_instr <= 1'b0;
    end else begin
      res_valid <= issue_valid;
      result    <= dec.legal ? alu_y : '0;
      dest_reg  <= dec.dest;
      wr_en     <= issue_valid & we_c;
      ovf_trap  <= issue_valid & dec.legal & alu_ovf;
      bad_instr <= issue_valid & ~dec.legal;
    end
  end

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_valid,
  input logic [5:0]        opc_f,
  input logic [4:0]        rt_f,
  input logic [4:0]        rd_f,
  input logic [15:0]       imm_f,
  input logic              res_valid,
  input logic [DATA_W-1:0] result,
  input logic [4:0]        dest_reg,
  input logic              wr_en,
  input logic              ovf_trap,
  input logic              bad_instr
);

  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> !wr_en); // R2

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    bad_instr |-> (!wr_en && !ovf_trap && result == '0)); // R11

  AST_ZERO_DEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> dest_reg != 5'd0); // R10

  AST_IDLE_FLAGS_LOW: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> (!res_valid && !wr_en && !ovf_trap && !bad_instr)); // R12

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> res_valid); // R1

  AST_REG_FMT_DEST: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && opc_f == 6'd0) |=> dest_reg == $past(rd_f)); // R1

  AST_IMM_FMT_DEST: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && opc_f != 6'd0) |=> dest_reg == $past(rt_f)); // R1

  AST_LUI_LAYOUT: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && opc_f == 6'd15) |=>
      (result[DATA_W-1 -: 16] == $past(imm_f) && result[DATA_W-17:0] == '0)); // R9

endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .opc_f       (instr[31:26]),
  .rt_f        (instr[20:16]),
  .rd_f        (instr[15:11]),
  .imm_f       (instr[15:0]),
  .res_valid   (res_valid),
  .result      (result),
  .dest_reg    (dest_reg),
  .wr_en       (wr_en),
  .ovf_trap    (ovf_trap),
  .bad_instr   (bad_instr)
);

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        res_valid;
  logic [31:0] result;
  logic [4:0]  dest_reg;
  logic        wr_en;
  logic        ovf_trap;
  logic        bad_instr;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  int_exec_unit #(.DATA_W(32)) uut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .result(result),
    .dest_reg(dest_reg), .wr_en(wr_en), .ovf_trap(ovf_trap), .bad_instr(bad_instr)
  );

  function automatic logic [31:0] pick(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7fff_ffff;
      3: return 32'h8000_0000;
      4: return 32'hffff_ffff;
      5: return 32'hffff_fff9;
      6: return 32'h1234_5678;
      default: return 32'h0000_ffa5;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] opc, input logic [5:0] fn);
    if (opc == 6'd0) begin
      case (fn)
        6'h20, 6'h22: return "R2";
        6'h21, 6'h23: return "R3";
        6'h24, 6'h25, 6'h26, 6'h27: return "R4";
        6'h2A, 6'h2B: return "R6";
        6'h00, 6'h02, 6'h03: return "R7";
        6'h04, 6'h06, 6'h07: return "R8";
        default: return "R11";
      endcase
    end
    case (opc)
      6'd8: return "R2";
      6'd9: return "R3";
      6'd10, 6'd11: return "R6";
      6'd12, 6'd13, 6'd14: return "R5";
      6'd15: return "R9";
      default: return "R11";
    endcase
  endfunction

  // expected {bad, ovf, we, dest, result}
  function automatic logic [39:0] model(input logic [31:0] w, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [5:0]  opc = w[31:26];
    logic [5:0]  fn  = w[5:0];
    logic [4:0]  sa  = w[10:6];
    logic [31:0] sx  = {{16{w[15]}}, w[15:0]};
    logic [31:0] zx  = {16'h0, w[15:0]};
    logic [31:0] r   = '0;
    logic        bad = 1'b0;
    logic        v   = 1'b0;
    longint      wide;
    logic [4:0]  dst = (opc == 6'd0) ? w[15:11] : w[20:16];
    if (opc == 6'd0) begin
      case (fn)
        6'h20: begin r = a + b; wide = longint'($signed(a)) + longint'($signed(b));
                     v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        6'h21: r = a + b;
        6'h22: begin r = a - b; wide = longint'($signed(a)) - longint'($signed(b));
                     v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        6'h23: r = a - b;
        6'h24: r = a & b;
        6'h25: r = a | b;
        6'h26: r = a ^ b;
        6'h27: r = ~(a | b);
        6'h2A: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'h2B: r = (a < b) ? 32'd1 : 32'd0;
        6'h00: r = b << sa;
        6'h02: r = b >> sa;
        6'h03: r = $unsigned($signed(b) >>> sa);
        6'h04: r = a << b[4:0];
        6'h06: r = a >> b[4:0];
        6'h07: r = $unsigned($signed(a) >>> b[4:0]);
        default: bad = 1'b1;
      endcase
    end else begin
      case (opc)
        6'd8: begin r = a + sx; wide = longint'($signed(a)) + longint'($signed(sx));
                    v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        6'd9:  r = a + sx;
        6'd10: r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
        6'd11: r = (a < sx) ? 32'd1 : 32'd0;
        6'd12: r = a & zx;
        6'd13: r = a | zx;
        6'd14: r = a ^ zx;
        6'd15: r = {w[15:0], 16'h0};
        default: bad = 1'b1;
      endcase
    end
    if (bad) r = '0;
    return {bad, v, (!bad && !v && dst != 5'd0), dst, r};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                       input string req);
    logic [39:0] exp;
    logic [39:0] got;
    @(negedge clk);
    instr = w; src_a = a; src_b = b; issue_valid = 1'b1;
    exp = model(w, a, b);
    @(negedge clk);
    issue_valid = 1'b0;
    got = {bad_instr, ovf_trap, wr_en, dest_reg, result};
    tests++;
    if (got !== exp || res_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s instr=%h a=%h b=%h got=%h/v%0b exp=%h/v1", req, w, a, b,
               got, res_valid, exp);
    end
  endtask

  task automatic check_quiet(input string req);
    tests++;
    if ({res_valid, wr_en, ovf_trap, bad_instr} !== 4'b0) begin
      fails++;
      $display("FAIL %s flags got=%b exp=0000", req, {res_valid, wr_en, ovf_trap, bad_instr});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    tests++;
    if ({res_valid, wr_en, ovf_trap, bad_instr, dest_reg, result} !== '0) begin
      fails++;
      $display("FAIL R12 reset got=%b exp=0", {res_valid, wr_en, ovf_trap, bad_instr});
    end

    // directed encodings and boundaries
    issue(32'h0064_1020, 32'd20, 32'd30, "R1 add encoding");
    tests++;
    if (result !== 32'd50 || dest_reg !== 5'd2) begin
      fails++; $display("FAIL R1 add got=%h/%0d exp=00000032/2", result, dest_reg);
    end
    issue(32'h0291_8822, 32'd40, 32'd50, "R1 sub encoding");
    tests++;
    if (result !== 32'hffff_fff6 || dest_reg !== 5'd17) begin
      fails++; $display("FAIL R1 sub got=%h/%0d exp=fffffff6/17", result, dest_reg);
    end
    issue(32'h3462_0004, 32'h0000_0010, 32'd0, "R5 ori encoding");
    issue(32'h0109_5020, 32'h7fff_ffff, 32'd1, "R2 add overflow");
    tests++;
    if (ovf_trap !== 1'b1 || wr_en !== 1'b0) begin
      fails++; $display("FAIL R2 trap got=%b%b exp=10", ovf_trap, wr_en);
    end
    issue(32'h0109_5021, 32'h7fff_ffff, 32'd1, "R3 addu wrap");
    tests++;
    if (result !== 32'h8000_0000 || ovf_trap !== 1'b0) begin
      fails++; $display("FAIL R3 wrap got=%h exp=80000000", result);
    end
    issue(32'h3408_ffff, 32'd0, 32'd0, "R5 ori zero-extend");
    tests++;
    if (result !== 32'h0000_ffff) begin
      fails++; $display("FAIL R5 got=%h exp=0000ffff", result);
    end
    issue(32'h2d28_ffff, 32'h8000_0000, 32'd0, "R6 sltiu sign-extended");
    tests++;
    if (result !== 32'd1) begin
      fails++; $display("FAIL R6 got=%h exp=00000001", result);
    end
    issue(32'h0009_4043, 32'd0, 32'hffff_fff9, "R7 sra fill");
    tests++;
    if (result !== 32'hffff_fffc) begin
      fails++; $display("FAIL R7 got=%h exp=fffffffc", result);
    end
    issue(32'h0009_40c2, 32'd0, 32'hffff_ffff, "R7 srl fill");
    tests++;
    if (result !== 32'h1fff_ffff) begin
      fails++; $display("FAIL R7 got=%h exp=1fffffff", result);
    end
    issue(32'h0000_0000, 32'd5, 32'd7, "R10 zero word");
    tests++;
    if (wr_en !== 1'b0) begin
      fails++; $display("FAIL R10 got=%b exp=0", wr_en);
    end
    issue(32'h3c08_1234, 32'd0, 32'd0, "R9 lui");
    @(negedge clk);
    check_quiet("R12 idle after issue");

    // exhaustive sweep over every opcode and every register-format function
    for (int op = 0; op < 64; op++) begin
      for (int k = 0; k < ((op == 0) ? 64 : 1); k++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            logic [31:0] w;
            logic [31:0] a;
            logic [31:0] b;
            a = pick(i);
            b = pick(j) ^ ((op == 0 && k >= 4 && k <= 7) ? 32'hffff_ff00 : 32'h0);
            if (op == 0)
              w = {6'd0, 5'(i + 1), 5'(j + 9), 5'((i * 5 + j) & 31), 5'(i * 3 + j * 7), 6'(k)};
            else
              w = {6'(op), 5'(i + 2), 5'((j * 3 + i) & 31), pick((i + j) & 7) [15:0] ^ 16'(j * 4097)};
            issue(w, a, b, tag_of(6'(op), 6'(k)));
          end
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule